// File: doc/BRIEF.md
# Indexed-Access System Counter Controller

This block is a small memory-mapped timer subsystem. It gives every CPU core one free-running counter and one interrupt line. A host reaches its internal registers only through a two-word window. The host first loads a register number into the selector word. It then reads or writes the value word, and that access goes to the selected internal register.

Two internal registers sit behind the window:
- **Global control register** (number 0x0). It holds one run bit and a one-hot divider field. One write of the run bit starts the shared 64-bit count for all cores at once.
- **Per-core interrupt mask** (number 0x30). Each core's event input reaches its interrupt output only while that core's mask bit is set.

The normal shutdown is to clear the mask bits. The run bit stays set, because other agents may still rely on the count.

The divider is a tick enable inside a single clock domain, not a derived clock. A 26 MHz input divided by 2 gives a 13 MHz count rate. Read data is registered: it appears in `busRdata` during the cycle after the read strobe and is zero in every other cycle.

Top module: `sys_counter_window`

## Requirements
- R1: After reset, the shared counter, every interrupt output and the read data are zero. A read of the selector word returns 0, and both internal registers read as 0.
- R2: A write at byte offset 0x4 loads the full 32-bit selector word. A read at byte offset 0x4 returns that word one cycle later.
- R3: A write at byte offset 0x0 goes to the internal register that the selector names. A read at byte offset 0x0 returns that register one cycle later. The control register keeps bit 0 (run) and bits 10:8 (divider); all its other bits read as zero.
- R4: Internal register 0x30 keeps one bit per core in bits NUM_CORES-1:0. Bit i belongs to core i, and the higher bits read as zero.
- R5: A selector value other than 0x0 or 0x30 reads as zero through offset 0x0. A write through offset 0x0 with such a selector changes neither internal register and does not start the counter.
- R6: While the run bit is 0, the counter does not change. From reset, it stays at zero whatever divider is written.
- R7: Divider field 3'b001 (bit 8): counting starts with the first clock edge after the run bit is set, and the counter then rises by one every edge.
- R8: Divider field 3'b010 (bit 9): N edges after the run bit is set, the counter holds floor(N/2).
- R9: Divider field 3'b100 (bit 10): N edges after the run bit is set, the counter holds floor(N/4).
- R10: A divider field that is zero or has more than one bit set counts like 3'b001. The field still reads back exactly as written.
- R11: Each `coreIrq[i]` equals `coreEvent[i]` AND mask bit i, registered one cycle. Clearing mask bits does not slow or stop the counter.
- R12: Clearing the run bit holds the counter at its current value. Setting the run bit again resumes counting from that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for the whole block |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Write strobe for the window |
| busRd | input | 1 | Read strobe for the window |
| busAddr | input | ADDR_W | Byte offset: 0x0 value word, 0x4 selector word, others ignored |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data, valid the cycle after busRd |
| coreEvent | input | NUM_CORES | Raw per-core timer events |
| cntValue | output | CNT_W | Shared count seen by all cores |
| coreIrq | output | NUM_CORES | Masked per-core interrupts |

## Verification
The bench builds the block with NUM_CORES = 4, CNT_W = 64 and ADDR_W = 3. With four cores, random masks and event patterns cover every combination of gating bits. With the full-width counter, counts from short runs can be compared exactly against floor(N/divider) for every legal and illegal divider code. A wrap of the 64-bit counter is out of reach at these run lengths, so the checks concentrate on start-up latency, divider rates, hold and resume, and decoding of selector values.

// File: rtl/sys_counter_pkg.sv
package sys_counter_pkg;
  localparam int unsigned BUS_W   = 32;
  localparam logic [BUS_W-1:0] IDX_CTRL = 32'h0000_0000;
  localparam logic [BUS_W-1:0] IDX_MASK = 32'h0000_0030;
  localparam int unsigned RUN_BIT = 0;
  localparam int unsigned DIV_LSB = 8;
  localparam int unsigned DIV_W   = 3;
  localparam logic [BUS_W-1:0] CTRL_KEEP = 32'h0000_0701;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_MASK = 2'd2
  } regSel_e;

  typedef struct packed {
    logic    wrCtrl;
    logic    wrMask;
    logic    rdIndex;
    logic    rdWin;
    regSel_e rdSel;
  } winStrobe_t;
endpackage

// File: rtl/sys_counter_ctrl.sv
module sys_counter_ctrl
  import sys_counter_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output winStrobe_t        strobe,
  output logic [BUS_W-1:0]  indexValue
);
  localparam logic [ADDR_W-1:0] OFF_DATA  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_INDEX = ADDR_W'(4);

  logic [BUS_W-1:0] indexReg;
  logic hitData, hitIndex;
  regSel_e selNow;

  assign hitData  = (busAddr == OFF_DATA);
  assign hitIndex = (busAddr == OFF_INDEX);

  always_ff @(posedge clk) begin
    if (!rstN)                indexReg <= '0;
    else if (busWr && hitIndex) indexReg <= busWdata;
  end

  always_comb begin
    if (indexReg == IDX_CTRL)      selNow = SEL_CTRL;
    else if (indexReg == IDX_MASK) selNow = SEL_MASK;
    else                           selNow = SEL_NONE;
  end

  always_comb begin
    strobe.wrCtrl  = busWr && hitData && (selNow == SEL_CTRL);
    strobe.wrMask  = busWr && hitData && (selNow == SEL_MASK);
    strobe.rdIndex = busRd && hitIndex;
    strobe.rdWin   = busRd && hitData;
    strobe.rdSel   = selNow;
  end

  assign indexValue = indexReg;

  // R2: a selector write lands in full on the next edge
  p_index_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == OFF_INDEX) |=> (indexValue == $past(busWdata)));

  // R3: at most one internal register is written per cycle
  p_one_target_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrCtrl, strobe.wrMask}));
endmodule

// File: rtl/sys_counter_core.sv
module sys_counter_core
  import sys_counter_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned CNT_W     = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  winStrobe_t           strobe,
  input  logic [BUS_W-1:0]     busWdata,
  input  logic [BUS_W-1:0]     indexValue,
  input  logic [NUM_CORES-1:0] coreEvent,
  output logic [BUS_W-1:0]     rdData,
  output logic [CNT_W-1:0]     cntValue,
  output logic [NUM_CORES-1:0] coreIrq
);
  localparam logic [BUS_W-1:0] MASK_KEEP = BUS_W'((65'(1) << NUM_CORES) - 65'(1));
  localparam int unsigned PRE_W = 2;

  logic [BUS_W-1:0] ctrlWord, maskWord;
  logic [PRE_W-1:0] preCnt;
  logic             runOn, tick;
  logic [DIV_W-1:0] divSel;
  logic [NUM_CORES-1:0] maskBits;
  logic [CNT_W-1:0] count;

  assign runOn    = ctrlWord[RUN_BIT];
  assign divSel   = ctrlWord[DIV_LSB +: DIV_W];
  assign maskBits = maskWord[NUM_CORES-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlWord <= '0;
      maskWord <= '0;
    end else begin
      if (strobe.wrCtrl) ctrlWord <= busWdata & CTRL_KEEP;
      if (strobe.wrMask) maskWord <= busWdata & MASK_KEEP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !runOn) preCnt <= '0;
    else                 preCnt <= preCnt + PRE_W'(1);
  end

  always_comb begin
    unique case (divSel)
      3'b010:  tick = runOn && preCnt[0];
      3'b100:  tick = runOn && (preCnt == 2'd3);
      default: tick = runOn;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)     count <= '0;
    else if (tick) count <= count + CNT_W'(1);
  end
  assign cntValue = count;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_irq
    always_ff @(posedge clk) begin
      if (!rstN) coreIrq[c] <= 1'b0;
      else       coreIrq[c] <= coreEvent[c] & maskBits[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else if (strobe.rdIndex) rdData <= indexValue;
    else if (strobe.rdWin) begin
      unique case (strobe.rdSel)
        SEL_CTRL: rdData <= ctrlWord;
        SEL_MASK: rdData <= maskWord;
        default:  rdData <= '0;
      endcase
    end else rdData <= '0;
  end

  // R6: no movement while the run bit is clear
  p_frozen_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    !runOn |=> (cntValue == $past(cntValue)));

  // R7: a running divide-by-1 counter steps every edge
  p_div1_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (runOn && divSel == 3'b001) |=> (cntValue == $past(cntValue) + CNT_W'(1)));

  // R8: never more than one step per edge
  p_single_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    runOn |=> (cntValue == $past(cntValue) || cntValue == $past(cntValue) + CNT_W'(1)));

  // R11: no interrupt from a masked core
  p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rstN)
    ((coreIrq & ~$past(maskBits)) == '0));

  // R5: unmapped selector reads zero
  p_unmapped_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdWin && strobe.rdSel == SEL_NONE) |=> (rdData == '0));
endmodule

// File: rtl/sys_counter_window.sv
module sys_counter_window
  import sys_counter_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned CNT_W     = 64,
  parameter int unsigned ADDR_W    = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWr,
  input  logic                 busRd,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  logic [NUM_CORES-1:0] coreEvent,
  output logic [CNT_W-1:0]     cntValue,
  output logic [NUM_CORES-1:0] coreIrq
);
  winStrobe_t       strobe;
  logic [BUS_W-1:0] indexValue;

  sys_counter_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWdata(busWdata),
    .strobe(strobe), .indexValue(indexValue)
  );

  sys_counter_core #(.NUM_CORES(NUM_CORES), .CNT_W(CNT_W)) u_core (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .indexValue(indexValue), .coreEvent(coreEvent),
    .rdData(busRdata), .cntValue(cntValue), .coreIrq(coreIrq)
  );
endmodule

// File: tb/test_sys_counter_window.sv
module test_sys_counter_window;
  localparam int NC = 4;
  localparam int CW = 64;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, busWr, busRd;
  logic [2:0] busAddr;
  logic [31:0] busWdata, busRdata;
  logic [NC-1:0] coreEvent, coreIrq;
  logic [CW-1:0] cntValue;
  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  sys_counter_window #(.NUM_CORES(NC), .CNT_W(CW), .ADDR_W(3)) i_sys_counter_window (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .coreEvent(coreEvent),
    .cntValue(cntValue), .coreIrq(coreIrq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [31:0] d);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [31:0] d);
    busRd = 1'b1; busAddr = a;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdata;
  endtask

  task automatic regWrite(input logic [31:0] idx, input logic [31:0] v);
    busWrite(3'h4, idx);
    busWrite(3'h0, v);
  endtask

  task automatic regRead(input logic [31:0] idx, output logic [31:0] v);
    busWrite(3'h4, idx);
    busRead(3'h0, v);
  endtask

  task automatic doReset();
    rstN = 1'b0; busWr = 1'b0; busRd = 1'b0; coreEvent = '0;
    busAddr = '0; busWdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  function automatic logic [63:0] expCount(input int edges, input logic [2:0] f);
    case (f)
      3'b010:  return 64'(edges / 2);
      3'b100:  return 64'(edges / 4);
      default: return 64'(edges);
    endcase
  endfunction

  function automatic logic [31:0] ctrlMasked(input logic [31:0] v);
    return v & 32'h0000_0701;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv, v, m;
    logic [63:0] snap;
    logic [2:0] fields [8] = '{3'b001, 3'b010, 3'b100, 3'b000, 3'b011, 3'b110, 3'b111, 3'b101};
    void'($urandom(32'h5EED_0042));
    rstN = 1'b0; busWr = 1'b0; busRd = 1'b0; coreEvent = '0; busAddr = '0; busWdata = '0;
    repeat (3) @(negedge clk);
    check("R1 counter", cntValue, 64'd0);
    check("R1 irq", 64'(coreIrq), 64'd0);
    check("R1 rdata", 64'(busRdata), 64'd0);
    rstN = 1'b1;
    busRead(3'h4, rv); check("R1 selector", 64'(rv), 64'd0);
    busRead(3'h0, rv); check("R1 control", 64'(rv), 64'd0);
    regRead(32'h30, rv); check("R1 mask", 64'(rv), 64'd0);

    // R2 selector readback
    for (int i = 0; i < 6; i++) begin
      v = $urandom;
      busWrite(3'h4, v);
      busRead(3'h4, rv);
      check("R2 selector", 64'(rv), 64'(v));
    end

    // R3 control field retention (run bit kept clear)
    for (int i = 0; i < 6; i++) begin
      v = $urandom & 32'hFFFF_FFFE;
      if (i == 0) v = 32'hFFFF_FFFE;
      regWrite(32'h0, v);
      regRead(32'h0, rv);
      check("R3 control", 64'(rv), 64'(ctrlMasked(v)));
    end

    // R4 mask width
    for (int i = 0; i < 6; i++) begin
      v = $urandom;
      regWrite(32'h30, v);
      regRead(32'h30, rv);
      check("R4 mask", 64'(rv), 64'(v & 32'hF));
    end

    // R5 unmapped selectors
    regWrite(32'h0, 32'h200);
    regWrite(32'h30, 32'h5);
    for (int i = 0; i < 5; i++) begin
      v = $urandom;
      if (v == 32'h0 || v == 32'h30) v = 32'h44;
      regWrite(v, 32'hFFFF_FFFF);
      regRead(v, rv);
      check("R5 unmapped read", 64'(rv), 64'd0);
    end
    regRead(32'h0, rv);  check("R5 control untouched", 64'(rv), 64'h200);
    regRead(32'h30, rv); check("R5 mask untouched", 64'(rv), 64'h5);
    check("R5 counter not started", cntValue, 64'd0);

    // R6 divider set, run bit clear
    regWrite(32'h0, 32'h400);
    repeat (20) @(negedge clk);
    check("R6 stays zero", cntValue, 64'd0);

    // R7 R8 R9 R10 divider rates
    for (int k = 0; k < 16; k++) begin
      logic [2:0] f;
      int n;
      string tag;
      f = fields[k % 8];
      n = 1 + int'($urandom % 40);
      tag = (f == 3'b001) ? "R7 div1" : (f == 3'b010) ? "R8 div2" :
            (f == 3'b100) ? "R9 div4" : "R10 invalid field";
      doReset();
      busWrite(3'h0, {21'd0, f, 8'd1});
      repeat (n) @(negedge clk);
      check(tag, cntValue, expCount(n, f));
      busRead(3'h0, rv);
      check("R10 field readback", 64'(rv), 64'({21'd0, f, 8'd1}));
    end

    // R12 hold and resume
    doReset();
    busWrite(3'h0, 32'h101);
    repeat (5) @(negedge clk);
    check("R12 before stop", cntValue, 64'd5);
    busWrite(3'h0, 32'h100);
    repeat (10) @(negedge clk);
    check("R12 held", cntValue, 64'd6);
    busWrite(3'h0, 32'h101);
    repeat (3) @(negedge clk);
    check("R12 resumed", cntValue, 64'd9);

    // R11 interrupt gating
    doReset();
    regWrite(32'h0, 32'h101);
    for (int i = 0; i < 4; i++) begin
      m = $urandom & 32'hF;
      regWrite(32'h30, m);
      for (int j = 0; j < 4; j++) begin
        logic [NC-1:0] ev;
        ev = NC'($urandom);
        coreEvent = ev;
        @(negedge clk);
        check("R11 irq gating", 64'(coreIrq), 64'(ev & m[NC-1:0]));
      end
    end
    coreEvent = '1;
    regWrite(32'h30, 32'h0);
    snap = cntValue;
    repeat (4) @(negedge clk);
    check("R11 masked irq", 64'(coreIrq), 64'd0);
    check("R11 counter runs after mask", cntValue, snap + 64'd4);
    coreEvent = '0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule